// File: doc/BRIEF.md
# Two-Word Burst Synchronous SRAM Core

This block is a synthesizable behavioural model of a synchronous static RAM in which every access moves a pair of data words. One command port is sampled on the rising clock edge. It carries an active-low load strobe, a read/write select and a word address. The two data beats that a double-rate bus would carry on opposite clock edges are presented side by side within the single clock domain: beat A is the first beat on the wire and beat B is the second.

Storage is organised as aligned pairs of words. The lowest address bit selects which word of the pair travels in beat A, and beat B always carries the other word of the same pair. A burst therefore wraps inside the pair and never steps into the next one. Write data and per-lane active-low write enables arrive in the cycle after the write command, and each beat has its own enables. Read data and a valid flag appear one cycle after the read command. A read that lands on a pair whose write is still pending sees the new bytes merged lane by lane.

Top module: `ddr_b2_sram`

## Requirements
- R1: While reset is held and after it is released, `rvalid` is low, both read-data outputs are zero, and every stored word reads back as zero.
- R2: In a cycle with `ld_n` high, no command is taken: `addr` and `rw` are ignored, `rvalid` is low in the next cycle, and the data and enables presented in that next cycle write nothing.
- R3: A loaded cycle with `rw` high is a read and with `rw` low is a write. A write never raises `rvalid`.
- R4: For a read of address `a`, `rdata_a` returns the word at `a` and `rdata_b` returns the word at `a` with bit 0 inverted. Both outputs hold their values until the next read completes.
- R5: For a write to address `a`, the values on `wdata_a` and `wdata_b` in the following cycle go to word `a` and to word `a` with bit 0 inverted, respectively.
- R6: Write enables are active low, with one bit per 9-bit lane: bit i covers data bits 9i+8 down to 9i. `wbe_a_n` masks beat A and `wbe_b_n` masks beat B independently, and a masked lane keeps its old content.
- R7: `rvalid` is high in exactly the cycle after a read command edge and low in every other cycle.
- R8: A read taken on the same edge that supplies a pending write's data returns the stored pair with the enabled lanes of that write already applied.
- R9: Write commands on consecutive edges are all carried out, each with the data supplied one cycle after its own command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_n | input | 1 | Active-low command load strobe |
| rw | input | 1 | 1 = read, 0 = write, used only when `ld_n` is low |
| addr | input | ADDR_W | Word address; bit 0 selects the first word of the burst |
| wdata_a | input | LANES*LANE_W | First write beat, one cycle after the write command |
| wdata_b | input | LANES*LANE_W | Second write beat, one cycle after the write command |
| wbe_a_n | input | LANES | Active-low lane enables for the first beat |
| wbe_b_n | input | LANES | Active-low lane enables for the second beat |
| rdata_a | output | LANES*LANE_W | First read beat |
| rdata_b | output | LANES*LANE_W | Second read beat |
| rvalid | output | 1 | Read data valid, one cycle after a read command |

## Verification
The hardest case to reach is a read of a pair on the exact edge where the write data for that same pair is being sampled, combined with different partial lane masks on the two beats and with either polarity of the start-word bit on both commands. Random traffic reaches this case only occasionally, so directed sequences first issue a write and then a read of the same pair with opposite start bits and mixed masks. Random traffic then follows on a small address range, which makes such collisions frequent. The reference model applies the pending write before it predicts the read result, so every collision is scored as a forwarding check.

// File: rtl/ddr_b2_pkg.sv
package ddr_b2_pkg;

    typedef enum logic [1:0] {
        CMD_IDLE  = 2'd0,
        CMD_READ  = 2'd1,
        CMD_WRITE = 2'd2
    } cmd_e;

    function automatic cmd_e cmd_decode(input logic load_n, input logic rd_sel);
        if (load_n) return CMD_IDLE;
        return rd_sel ? CMD_READ : CMD_WRITE;
    endfunction

endpackage

// File: rtl/ddr_b2_lane_merge.sv
module ddr_b2_lane_merge #(
    parameter int LANES  = 4,
    parameter int LANE_W = 9,
    localparam int DW    = LANES * LANE_W
) (
    input  logic [DW-1:0]    old_word,
    input  logic [DW-1:0]    new_word,
    input  logic [LANES-1:0] en_n,
    output logic [DW-1:0]    merged
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign merged[g*LANE_W +: LANE_W] = en_n[g] ? old_word[g*LANE_W +: LANE_W]
                                                    : new_word[g*LANE_W +: LANE_W];
    end
endmodule

// File: rtl/ddr_b2_store.sv
module ddr_b2_store #(
    parameter int PAIR_W = 5,
    parameter int DW     = 36,
    localparam int PAIRS = 1 << PAIR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [PAIR_W-1:0] wpair,
    input  logic [DW-1:0]     wd0,
    input  logic [DW-1:0]     wd1,
    output logic [DW-1:0]     old0,
    output logic [DW-1:0]     old1,
    input  logic [PAIR_W-1:0] rpair,
    output logic [DW-1:0]     rd0,
    output logic [DW-1:0]     rd1
);
    logic [DW-1:0] mem0_q [PAIRS];
    logic [DW-1:0] mem1_q [PAIRS];
    logic [DW-1:0] mem0_d [PAIRS];
    logic [DW-1:0] mem1_d [PAIRS];

    assign old0 = mem0_q[wpair];
    assign old1 = mem1_q[wpair];
    assign rd0  = mem0_q[rpair];
    assign rd1  = mem1_q[rpair];

    always_comb begin
        mem0_d = mem0_q;
        mem1_d = mem1_q;
        if (we) begin
            mem0_d[wpair] = wd0;
            mem1_d[wpair] = wd1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < PAIRS; i++) begin
                mem0_q[i] <= '0;
                mem1_q[i] <= '0;
            end
        end else begin
            mem0_q <= mem0_d;
            mem1_q <= mem1_d;
        end
    end

    // R5
    store_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (mem0_q[$past(wpair)] == $past(wd0)) && (mem1_q[$past(wpair)] == $past(wd1)));
endmodule

// File: rtl/ddr_b2_ctrl.sv
module ddr_b2_ctrl
    import ddr_b2_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int DW     = 36,
    localparam int PAIR_W = ADDR_W - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_n,
    input  logic              rw,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DW-1:0]     new0,
    input  logic [DW-1:0]     new1,
    input  logic [DW-1:0]     st0,
    input  logic [DW-1:0]     st1,
    output logic              pend_v,
    output logic [PAIR_W-1:0] pend_pair,
    output logic              pend_lsb,
    output logic [PAIR_W-1:0] rd_pair,
    output logic              rvalid,
    output logic [DW-1:0]     rdata_a,
    output logic [DW-1:0]     rdata_b
);
    typedef struct packed {
        logic              pv;
        logic [PAIR_W-1:0] pp;
        logic              pl;
        logic              rv;
        logic [DW-1:0]     ra;
        logic [DW-1:0]     rb;
    } st_t;

    st_t  s_d, s_q;
    cmd_e cmd;
    logic hit;
    logic [DW-1:0] w0, w1;

    assign rd_pair = addr[ADDR_W-1:1];

    always_comb begin
        s_d = s_q;
        cmd = cmd_decode(ld_n, rw);
        hit = s_q.pv && (s_q.pp == rd_pair);
        w0  = hit ? new0 : st0;
        w1  = hit ? new1 : st1;
        s_d.pv = (cmd == CMD_WRITE);
        s_d.pp = rd_pair;
        s_d.pl = addr[0];
        s_d.rv = (cmd == CMD_READ);
        if (cmd == CMD_READ) begin
            s_d.ra = addr[0] ? w1 : w0;
            s_d.rb = addr[0] ? w0 : w1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign pend_v    = s_q.pv;
    assign pend_pair = s_q.pp;
    assign pend_lsb  = s_q.pl;
    assign rvalid    = s_q.rv;
    assign rdata_a   = s_q.ra;
    assign rdata_b   = s_q.rb;

    // R3
    wr_no_rv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_n && !rw) |=> (!rvalid && pend_v));
    // R9
    pend_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pend_v |-> ($past(!ld_n) && !$past(rw)));
endmodule

// File: rtl/ddr_b2_sram.sv
module ddr_b2_sram #(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 9,
    localparam int DW     = LANES * LANE_W,
    localparam int PAIR_W = ADDR_W - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_n,
    input  logic              rw,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DW-1:0]     wdata_a,
    input  logic [DW-1:0]     wdata_b,
    input  logic [LANES-1:0]  wbe_a_n,
    input  logic [LANES-1:0]  wbe_b_n,
    output logic [DW-1:0]     rdata_a,
    output logic [DW-1:0]     rdata_b,
    output logic              rvalid
);
    logic              pend_v, pend_lsb;
    logic [PAIR_W-1:0] pend_pair, rd_pair;
    logic [DW-1:0]     old0, old1, st0, st1, new0, new1;
    logic [DW-1:0]     beat0, beat1;
    logic [LANES-1:0]  en0_n, en1_n;

    // beat A lands on the word chosen by the start bit, beat B on its partner
    assign beat0 = pend_lsb ? wdata_b : wdata_a;
    assign beat1 = pend_lsb ? wdata_a : wdata_b;
    assign en0_n = pend_lsb ? wbe_b_n : wbe_a_n;
    assign en1_n = pend_lsb ? wbe_a_n : wbe_b_n;

    ddr_b2_lane_merge #(.LANES(LANES), .LANE_W(LANE_W)) i_merge0 (
        .old_word(old0), .new_word(beat0), .en_n(en0_n), .merged(new0));
    ddr_b2_lane_merge #(.LANES(LANES), .LANE_W(LANE_W)) i_merge1 (
        .old_word(old1), .new_word(beat1), .en_n(en1_n), .merged(new1));

    ddr_b2_store #(.PAIR_W(PAIR_W), .DW(DW)) i_store (
        .clk(clk), .rst_n(rst_n), .we(pend_v), .wpair(pend_pair),
        .wd0(new0), .wd1(new1), .old0(old0), .old1(old1),
        .rpair(rd_pair), .rd0(st0), .rd1(st1));

    ddr_b2_ctrl #(.ADDR_W(ADDR_W), .DW(DW)) i_ctrl (
        .clk(clk), .rst_n(rst_n), .ld_n(ld_n), .rw(rw), .addr(addr),
        .new0(new0), .new1(new1), .st0(st0), .st1(st1),
        .pend_v(pend_v), .pend_pair(pend_pair), .pend_lsb(pend_lsb),
        .rd_pair(rd_pair), .rvalid(rvalid), .rdata_a(rdata_a), .rdata_b(rdata_b));

    // R2
    noop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld_n |=> !rvalid);
    // R7
    rd_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_n && rw) |=> rvalid);
    // R1
    rst_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!rvalid && rdata_a == '0 && rdata_b == '0));
endmodule

// File: tb/test_ddr_b2_sram.sv
`timescale 1ns/1ps
module test_ddr_b2_sram;
    localparam int AW = 6, LN = 4, LW = 9, DW = LN * LW, WORDS = 1 << AW;

    logic clk = 1'b0, rst_n = 1'b0, ld_n = 1'b1, rw = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wdata_a = '0, wdata_b = '0;
    logic [LN-1:0] wbe_a_n = '1, wbe_b_n = '1;
    logic [DW-1:0] rdata_a, rdata_b;
    logic rvalid;

    int n_cmp = 0, n_bad = 0;
    bit done = 0;

    logic [DW-1:0] mdl [WORDS];
    logic          p_v = 0;
    logic [AW-1:0] p_a = '0;
    logic          e_rv = 0;
    logic [DW-1:0] e_a = '0, e_b = '0;

    always #2.5 clk = ~clk;

    ddr_b2_sram #(.ADDR_W(AW), .LANES(LN), .LANE_W(LW)) i_ddr_b2_sram (
        .clk(clk), .rst_n(rst_n), .ld_n(ld_n), .rw(rw), .addr(addr),
        .wdata_a(wdata_a), .wdata_b(wdata_b), .wbe_a_n(wbe_a_n), .wbe_b_n(wbe_b_n),
        .rdata_a(rdata_a), .rdata_b(rdata_b), .rvalid(rvalid));

    function automatic logic [DW-1:0] mrg(input logic [DW-1:0] o, input logic [DW-1:0] n,
                                          input logic [LN-1:0] en_n);
        logic [DW-1:0] r = o;
        for (int i = 0; i < LN; i++)
            if (!en_n[i]) r[i*LW +: LW] = n[i*LW +: LW];
        return r;
    endfunction

    task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // one clock: drive after a falling edge, predict, then compare at the next falling edge
    task automatic cyc(input logic l, input logic r, input logic [AW-1:0] a,
                       input logic [DW-1:0] wa, input logic [DW-1:0] wb,
                       input logic [LN-1:0] ea, input logic [LN-1:0] eb, input string tag);
        string rvt, dt;
        bit hit;
        ld_n = l; rw = r; addr = a; wdata_a = wa; wdata_b = wb; wbe_a_n = ea; wbe_b_n = eb;
        hit = p_v && (p_a[AW-1:1] == a[AW-1:1]);
        if (p_v) begin
            mdl[p_a]        = mrg(mdl[p_a], wa, ea);
            mdl[p_a ^ 6'd1] = mrg(mdl[p_a ^ 6'd1], wb, eb);
        end
        e_rv = !l && r;
        if (e_rv) begin
            e_a = mdl[a];
            e_b = mdl[a ^ 6'd1];
        end
        p_v = !l && !r;
        p_a = a;
        rvt = (!l && r) ? "R7" : (l ? "R2" : "R3");
        dt  = (e_rv && hit) ? "R8" : tag;
        @(posedge clk);
        @(negedge clk);
        chk(rvt, DW'(rvalid), DW'(e_rv));
        chk({dt, " beatA"}, rdata_a, e_a);
        chk({dt, " beatB"}, rdata_b, e_b);
    endtask

    task automatic idle();
        cyc(1'b1, 1'b0, '0, '0, '0, '1, '1, "R4");
    endtask

    initial begin
        #(150000 * 5.0);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < WORDS; i++) mdl[i] = '0;
        void'($urandom(32'd7919));
        repeat (4) @(negedge clk);
        chk("R1 rvalid in reset", DW'(rvalid), '0);
        chk("R1 rdata in reset", rdata_a | rdata_b, '0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 rvalid after reset", DW'(rvalid), '0);
        // R1: every pair reads back zero
        for (int i = 0; i < WORDS; i += 2) cyc(1'b0, 1'b1, AW'(i), '0, '0, '1, '1, "R1");

        // R5/R4: write at odd start, read back at both starts
        cyc(1'b0, 1'b0, 6'd5, '0, '0, '1, '1, "R4");
        cyc(1'b1, 1'b0, '0, 36'hA_AAAA_0001, 36'hB_BBBB_0002, 4'h0, 4'h0, "R5");
        cyc(1'b0, 1'b1, 6'd5, '0, '0, '1, '1, "R5");
        cyc(1'b0, 1'b1, 6'd4, '0, '0, '1, '1, "R4");

        // R6/R8: write with per-beat masks, read same pair on the data edge
        cyc(1'b0, 1'b0, 6'd10, '0, '0, '1, '1, "R4");
        cyc(1'b0, 1'b1, 6'd11, 36'h1_2345_6789, 36'hF_EDCB_A987, 4'b1010, 4'b0101, "R6");
        cyc(1'b0, 1'b1, 6'd10, '0, '0, '1, '1, "R6");

        // R2: idle command with garbage, then data with all enables low must not land
        cyc(1'b1, 1'b0, 6'd20, '0, '0, '1, '1, "R2");
        cyc(1'b1, 1'b1, 6'd21, 36'hF_FFFF_FFFF, 36'hF_FFFF_FFFF, 4'h0, 4'h0, "R2");
        cyc(1'b0, 1'b1, 6'd20, '0, '0, '1, '1, "R2");

        // R9: back-to-back writes
        cyc(1'b0, 1'b0, 6'd30, '0, '0, '1, '1, "R9");
        cyc(1'b0, 1'b0, 6'd33, 36'h3_0303_0303, 36'h3_1313_1313, 4'h0, 4'h0, "R9");
        cyc(1'b0, 1'b0, 6'd36, 36'h3_3333_3333, 36'h3_2323_2323, 4'h0, 4'h0, "R9");
        cyc(1'b0, 1'b1, 6'd30, 36'h3_6666_6666, 36'h3_7777_7777, 4'h0, 4'hC, "R9");
        cyc(1'b0, 1'b1, 6'd32, '0, '0, '1, '1, "R9");
        cyc(1'b0, 1'b1, 6'd37, '0, '0, '1, '1, "R9");

        // random traffic on a narrow then full address range
        for (int k = 0; k < 6000; k++) begin
            logic [AW-1:0] a;
            a = (k < 3000) ? AW'($urandom_range(0, 7)) : AW'($urandom);
            cyc(($urandom_range(0, 3) == 0), 1'($urandom), a,
                {4'($urandom), 32'($urandom)}, {4'($urandom), 32'($urandom)},
                4'($urandom), 4'($urandom), "R4");
        end
        idle();
        // full readback of the array
        for (int i = 0; i < WORDS; i += 2) cyc(1'b0, 1'b1, AW'(i), '0, '0, '1, '1, "R5");
        idle();

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule